// File: doc/BRIEF.md
# Buffered Parallel Port Controller

This block is one 8-bit parallel port seen by a processor through a byte-wide register window. The processor selects a register with a 5-bit offset, qualifies the access with a chip select, and issues a read or write strobe. Five registers are decoded. A general control register holds the mode, the handshake pair enables and the per-line sense bits. A port control register holds the submode and the interrupt enables. A direction register gives one bit per pin. The data register connects to the pins and buffers. A status register shows the four handshake lines and four flags.

A separate handshake block sits beside this port. It drives a strobe with each incoming byte and takes a ready signal back. It sees a valid signal for the outgoing byte and returns an acknowledge. It also supplies the four raw handshake line levels.

The submode picks one of three buffering schemes:
- A two-stage input with a single output register.
- A live (non-latched) input with a two-stage output.
- A live input with a single output register.

The port raises a registered interrupt request from the two low status flags and their enables.

Top module: `bpp_port`

## Requirements
- R1: A synchronous active-high reset clears the general control, port control and direction registers, the sticky flags and both buffers. After reset `pin_oe` is 0, `irq` is 0, `out_vld` is 0, `in_rdy` is 1 and `rdata` is 0.
- R2: The decoded offsets are 0x00 (general control), 0x04 (direction), 0x0C (port control), 0x10 (data) and 0x1A (status). The control registers read back what was written. A read of any other offset returns 0, and a write to any other offset changes nothing. An access without `cs` is ignored. Read data appears on `rdata` one clock after the read strobe.
- R3: `pin_oe` equals the direction register: bit i = 1 makes pin i an output, 0 makes it an input.
- R4: With port control bits 7:6 = 00, each `in_stb` captures `pin_in`. The first byte goes to the head stage and a second byte goes to a holding stage. `in_rdy` is 0 while both stages are full, and a strobe arriving then is dropped. Each read of the data register returns the head and advances the queue.
- R5: With port control bits 7:6 = 01 or 1x, a data read returns the live level of `pin_in` on the input bits, and `in_rdy` stays 1.
- R6: On a data read, bits whose direction is 1 return the output register, and the other bits return the input source.
- R7: With bits 7:6 = 00 or 1x, a data write loads `pin_out` at once and sets `out_vld`. An `out_ack` while nothing is held clears `out_vld`.
- R8: With bits 7:6 = 01, a write made while `out_vld` is set is held back and `pin_out` is unchanged. An `out_ack` moves the held byte to `pin_out`. A write made while a byte is already held is dropped.
- R9: Status bits 7:4 read the current levels of lines 3..0.
- R10: Status flag i (bits 3:0) sets when line i becomes asserted, with general control bit i as its sense (1 = high asserted, 0 = low asserted). The flag only sets when its pair is enabled: general control bit 4 enables lines 0/1 and bit 5 enables lines 2/3. Writing 1 to status bit i clears the flag, and writing 0 leaves it unchanged.
- R11: In submode 00, status bit 0 shows that the input head holds a byte, and writing 1 does not clear it. In submode 01, status bit 1 shows that the output holding stage is empty.
- R12: `irq` is registered and equals (status bit 0 AND port control bit 1) OR (status bit 1 AND port control bit 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| reg_sel | input | 5 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Pin input levels |
| pin_out | output | 8 | Output register to pins |
| pin_oe | output | 8 | Per-pin output enable |
| in_stb | input | 1 | Input byte strobe from handshake block |
| in_rdy | output | 1 | Input stages can accept a byte |
| out_vld | output | 1 | Output byte pending for peripheral |
| out_ack | input | 1 | Peripheral took the output byte |
| hs_lvl | input | 4 | Handshake line levels, bit i = line i |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted input queue shows up on the first data read after the bad strobe. The fault appears as a repeated byte, a swapped order, a lost second byte, or an `in_rdy` that never drops. A broken output holding stage shows on `pin_out` right after a write or an acknowledge. Sticky flag errors appear in the low nibble of the next status read. They reach `irq` two clocks after the line edge, and a missing write-one clear leaves `irq` high indefinitely.

// File: rtl/bpp_pkg.sv
package bpp_pkg;
  localparam int unsigned AW = 5;
  localparam int unsigned NL = 4;
  localparam logic [AW-1:0] OFS_GCR = 5'h00;
  localparam logic [AW-1:0] OFS_DDR = 5'h04;
  localparam logic [AW-1:0] OFS_PCR = 5'h0C;
  localparam logic [AW-1:0] OFS_DAT = 5'h10;
  localparam logic [AW-1:0] OFS_STS = 5'h1A;

  typedef enum logic [1:0] {
    SUB_DBIN  = 2'b00,
    SUB_DBOUT = 2'b01,
    SUB_LIVE0 = 2'b10,
    SUB_LIVE1 = 2'b11
  } sub_e;
endpackage

// File: rtl/bpp_regs.sv
module bpp_regs #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_gcr,
  input  logic          wr_ddr,
  input  logic          wr_pcr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] gcr_q,
  output logic [DW-1:0] ddr_q,
  output logic [DW-1:0] pcr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      gcr_q <= '0;
      ddr_q <= '0;
      pcr_q <= '0;
    end else begin
      if (wr_gcr) gcr_q <= wdata;
      if (wr_ddr) ddr_q <= wdata;
      if (wr_pcr) pcr_q <= wdata;
    end
  end
endmodule

// File: rtl/bpp_inbuf.sv
module bpp_inbuf #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dbl,
  input  logic          in_stb,
  input  logic          pop,
  input  logic [DW-1:0] pin_in,
  output logic [DW-1:0] head,
  output logic          head_v,
  output logic          in_rdy
);
  logic [DW-1:0] tail;
  logic          tail_v;
  logic          push, take;

  assign in_rdy = !(dbl && tail_v);
  assign push   = in_stb && dbl && !tail_v;
  assign take   = pop && dbl && head_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      head   <= '0;
      tail   <= '0;
      head_v <= 1'b0;
      tail_v <= 1'b0;
    end else if (take) begin
      if (tail_v) begin
        head   <= tail;
        tail_v <= 1'b0;
      end else if (push) begin
        head   <= pin_in;
      end else begin
        head_v <= 1'b0;
      end
    end else if (push) begin
      if (!head_v) begin
        head   <= pin_in;
        head_v <= 1'b1;
      end else begin
        tail   <= pin_in;
        tail_v <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bpp_outbuf.sv
module bpp_outbuf #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dbl,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          ack,
  output logic [DW-1:0] oreg,
  output logic          ovld,
  output logic          hold_v
);
  logic [DW-1:0] hold, n_oreg, n_hold;
  logic          n_ovld, n_hold_v;

  always_comb begin
    n_oreg   = oreg;
    n_ovld   = ovld;
    n_hold   = hold;
    n_hold_v = hold_v;
    if (ack && ovld) begin
      if (hold_v) begin
        n_oreg   = hold;
        n_hold_v = 1'b0;
      end else begin
        n_ovld = 1'b0;
      end
    end
    if (wr) begin
      if (!dbl || !n_ovld) begin
        n_oreg = wdata;
        n_ovld = 1'b1;
      end else if (!n_hold_v) begin
        n_hold   = wdata;
        n_hold_v = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oreg   <= '0;
      ovld   <= 1'b0;
      hold   <= '0;
      hold_v <= 1'b0;
    end else begin
      oreg   <= n_oreg;
      ovld   <= n_ovld;
      hold   <= n_hold;
      hold_v <= n_hold_v;
    end
  end
endmodule

// File: rtl/bpp_status.sv
module bpp_status #(
  parameter int unsigned NL = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NL-1:0] lvl,
  input  logic [NL-1:0] sense,
  input  logic [NL/2-1:0] pair_en,
  input  logic          clr,
  input  logic [NL-1:0] clr_mask,
  output logic [NL-1:0] flag
);
  logic [NL-1:0] act, act_d, rise;

  for (genvar g = 0; g < NL; g++) begin : g_line
    assign act[g]  = lvl[g] ~^ sense[g];
    assign rise[g] = act[g] && !act_d[g] && pair_en[g/2];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_d <= '0;
      flag  <= '0;
    end else begin
      act_d <= act;
      for (int i = 0; i < NL; i++) begin
        if (rise[i])                  flag[i] <= 1'b1;
        else if (clr && clr_mask[i])  flag[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bpp_port.sv
module bpp_port
  import bpp_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [4:0]    reg_sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] pin_in,
  output logic [DW-1:0] pin_out,
  output logic [DW-1:0] pin_oe,
  input  logic          in_stb,
  output logic          in_rdy,
  output logic          out_vld,
  input  logic          out_ack,
  input  logic [3:0]    hs_lvl,
  output logic          irq
);
  logic [DW-1:0] gcr_q, ddr_q, pcr_q;
  logic [DW-1:0] head, in_src, dat_view, rd_mux;
  logic [NL-1:0] flag, stat_lo;
  logic          wacc, racc, head_v, hold_v;
  logic          dbl_in, dbl_out;
  sub_e          sub;

  assign wacc    = cs && wr_en;
  assign racc    = cs && rd_en;
  assign sub     = sub_e'(pcr_q[7:6]);
  assign dbl_in  = (sub == SUB_DBIN);
  assign dbl_out = (sub == SUB_DBOUT);

  bpp_regs #(.DW(DW)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .wr_gcr(wacc && reg_sel == OFS_GCR),
    .wr_ddr(wacc && reg_sel == OFS_DDR),
    .wr_pcr(wacc && reg_sel == OFS_PCR),
    .wdata (wdata),
    .gcr_q (gcr_q),
    .ddr_q (ddr_q),
    .pcr_q (pcr_q)
  );

  bpp_inbuf #(.DW(DW)) u_inbuf (
    .clk   (clk),
    .rst   (rst),
    .dbl   (dbl_in),
    .in_stb(in_stb),
    .pop   (racc && reg_sel == OFS_DAT),
    .pin_in(pin_in),
    .head  (head),
    .head_v(head_v),
    .in_rdy(in_rdy)
  );

  bpp_outbuf #(.DW(DW)) u_outbuf (
    .clk   (clk),
    .rst   (rst),
    .dbl   (dbl_out),
    .wr    (wacc && reg_sel == OFS_DAT),
    .wdata (wdata),
    .ack   (out_ack),
    .oreg  (pin_out),
    .ovld  (out_vld),
    .hold_v(hold_v)
  );

  bpp_status #(.NL(NL)) u_status (
    .clk     (clk),
    .rst     (rst),
    .lvl     (hs_lvl),
    .sense   (gcr_q[NL-1:0]),
    .pair_en (gcr_q[5:4]),
    .clr     (wacc && reg_sel == OFS_STS),
    .clr_mask(wdata[NL-1:0]),
    .flag    (flag)
  );

  assign pin_oe   = ddr_q;
  assign in_src   = dbl_in ? head : pin_in;
  assign dat_view = (pin_out & ddr_q) | (in_src & ~ddr_q);
  assign stat_lo  = {flag[3:2], dbl_out ? !hold_v : flag[1], dbl_in ? head_v : flag[0]};

  always_comb begin
    unique case (reg_sel)
      OFS_GCR: rd_mux = gcr_q;
      OFS_DDR: rd_mux = ddr_q;
      OFS_PCR: rd_mux = pcr_q;
      OFS_DAT: rd_mux = dat_view;
      OFS_STS: rd_mux = {hs_lvl, stat_lo};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      if (racc) rdata <= rd_mux;
      irq <= (stat_lo[0] && pcr_q[1]) || (stat_lo[1] && pcr_q[2]);
    end
  end
endmodule

// File: rtl/bpp_port_chk.sv
module bpp_port_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs,
  input logic       rd_en,
  input logic       wr_en,
  input logic [4:0] reg_sel,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic [7:0] pin_oe,
  input logic       in_stb,
  input logic       in_rdy,
  input logic       out_vld,
  input logic       out_ack,
  input logic       irq,
  input logic [7:0] pcr_q,
  input logic       hold_v
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (pin_oe == 8'h00 && !irq && !out_vld && rdata == 8'h00)); // R1

  AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (rst)
    (cs && wr_en && reg_sel == 5'h08) |=> $stable(pin_oe)); // R2

  AST_OE_FOLLOWS_DDR: assert property (@(posedge clk) disable iff (rst)
    (cs && wr_en && reg_sel == 5'h04) |=> pin_oe == $past(wdata)); // R3

  AST_FULL_STAYS_FULL: assert property (@(posedge clk) disable iff (rst)
    (in_stb && !in_rdy && !(cs && (rd_en || wr_en))) |=> !in_rdy); // R4

  AST_SB_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (out_ack && out_vld && !hold_v && pcr_q[7:6] != 2'b01 &&
     !(cs && wr_en && reg_sel == 5'h10)) |=> !out_vld); // R7

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(pcr_q[2]) || $past(pcr_q[1]))); // R12
endmodule

bind bpp_port bpp_port_chk u_chk (
  .clk(clk), .rst(rst), .cs(cs), .rd_en(rd_en), .wr_en(wr_en),
  .reg_sel(reg_sel), .wdata(wdata), .rdata(rdata), .pin_oe(pin_oe),
  .in_stb(in_stb), .in_rdy(in_rdy), .out_vld(out_vld), .out_ack(out_ack),
  .irq(irq), .pcr_q(pcr_q), .hold_v(hold_v)
);

// File: tb/bpp_port_tb.sv
module bpp_port_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs = 0, rd_en = 0, wr_en = 0, in_stb = 0, out_ack = 0;
  logic [4:0] reg_sel = '0;
  logic [7:0] wdata = '0, pin_in = '0;
  logic [3:0] hs_lvl = 4'hF;
  logic [7:0] rdata, pin_out, pin_oe;
  logic       in_rdy, out_vld, irq;
  int         n_chk = 0, n_err = 0;
  logic [7:0] v;

  always #10 clk = ~clk;

  bpp_port u_dut (
    .clk(clk), .rst(rst), .cs(cs), .rd_en(rd_en), .wr_en(wr_en),
    .reg_sel(reg_sel), .wdata(wdata), .rdata(rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .in_stb(in_stb), .in_rdy(in_rdy),
    .out_vld(out_vld), .out_ack(out_ack), .hs_lvl(hs_lvl), .irq(irq)
  );

  localparam logic [4:0] GCR = 5'h00, DDR = 5'h04, PCR = 5'h0C, DAT = 5'h10, STS = 5'h1A;

  // {offset, write value, expected read}
  localparam logic [20:0] VEC [6] = '{
    {GCR,   8'hC0, 8'hC0},
    {DDR,   8'h3C, 8'h3C},
    {PCR,   8'hC0, 8'hC0},
    {5'h08, 8'h77, 8'h00},
    {5'h1F, 8'h55, 8'h00},
    {5'h02, 8'hFF, 8'h00}
  };

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); cs = 1; wr_en = 1; reg_sel = a; wdata = d;
    @(negedge clk); cs = 0; wr_en = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); cs = 1; rd_en = 1; reg_sel = a;
    @(negedge clk); d = rdata; cs = 0; rd_en = 0;
  endtask

  task automatic strobe(input logic [7:0] d);
    @(negedge clk); pin_in = d; in_stb = 1;
    @(negedge clk); in_stb = 0;
  endtask

  task automatic ack;
    @(negedge clk); out_ack = 1;
    @(negedge clk); out_ack = 0;
  endtask

  task automatic line_pulse(input int i);
    @(negedge clk); hs_lvl[i] = ~hs_lvl[i];
    @(negedge clk); hs_lvl[i] = ~hs_lvl[i];
    tick(2);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    tick(3); rst = 0; tick(1);
    // R1 reset state
    check("R1 pin_oe", pin_oe, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);
    check("R1 out_vld", {7'b0, out_vld}, 8'h00);
    check("R1 in_rdy", {7'b0, in_rdy}, 8'h01);
    check("R1 rdata", rdata, 8'h00);
    rd(PCR, v); check("R1 pcr", v, 8'h00);

    // R2 table walk
    foreach (VEC[i]) begin
      wr(VEC[i][20:16], VEC[i][15:8]);
      rd(VEC[i][20:16], v);
      check("R2 readback", v, VEC[i][7:0]);
    end
    @(negedge clk); cs = 0; wr_en = 1; reg_sel = DDR; wdata = 8'hFF;
    @(negedge clk); wr_en = 0;
    rd(DDR, v); check("R2 no cs", v, 8'h3C);
    wr(GCR, 8'h00); wr(PCR, 8'h00);

    // R3
    wr(DDR, 8'hF0); check("R3 pin_oe", pin_oe, 8'hF0);
    wr(DDR, 8'h00);

    // R4 / R11 two-stage input
    strobe(8'h11);
    check("R4 rdy after one", {7'b0, in_rdy}, 8'h01);
    strobe(8'h22);
    check("R4 rdy full", {7'b0, in_rdy}, 8'h00);
    strobe(8'h33);
    wr(STS, 8'h0F);
    rd(STS, v); check("R11 in flag held", v & 8'h0F, 8'h01);
    rd(DAT, v); check("R4 first byte", v, 8'h11);
    check("R4 rdy after pop", {7'b0, in_rdy}, 8'h01);
    rd(DAT, v); check("R4 second byte", v, 8'h22);
    rd(STS, v); check("R11 in empty", v & 8'h0F, 8'h00);

    // R5 live input
    wr(PCR, 8'h80);
    pin_in = 8'h5A; rd(DAT, v); check("R5 live a", v, 8'h5A);
    pin_in = 8'hA5; rd(DAT, v); check("R5 live b", v, 8'hA5);
    check("R5 in_rdy", {7'b0, in_rdy}, 8'h01);

    // R6 / R7 single output
    wr(DDR, 8'hF0); wr(DAT, 8'h9C);
    check("R7 pin_out", pin_out, 8'h9C);
    check("R7 out_vld", {7'b0, out_vld}, 8'h01);
    pin_in = 8'h03; rd(DAT, v); check("R6 mixed read", v, 8'h93);
    ack; check("R7 ack clears", {7'b0, out_vld}, 8'h00);

    // R8 / R11 double output
    wr(PCR, 8'h40); wr(DDR, 8'hFF);
    wr(DAT, 8'h11);
    rd(STS, v); check("R11 room", v & 8'h02, 8'h02);
    wr(DAT, 8'h22);
    check("R8 first stays", pin_out, 8'h11);
    rd(STS, v); check("R11 no room", v & 8'h02, 8'h00);
    wr(DAT, 8'h33);
    ack; check("R8 held moves", pin_out, 8'h22);
    check("R8 vld kept", {7'b0, out_vld}, 8'h01);
    ack; check("R8 drained", {7'b0, out_vld}, 8'h00);
    check("R8 third dropped", pin_out, 8'h22);

    // R9 levels
    wr(PCR, 8'h80); wr(DDR, 8'h00);
    hs_lvl = 4'hA; rd(STS, v); check("R9 levels", v & 8'hF0, 8'hA0);
    hs_lvl = 4'hF; tick(2);

    // R10 sticky flags
    wr(GCR, 8'h30); wr(STS, 8'h0F);
    @(negedge clk); hs_lvl[0] = 1'b0;
    @(negedge clk); hs_lvl[0] = 1'b1; tick(2);
    rd(STS, v); check("R10 set low", v, 8'hF1);
    wr(STS, 8'h00); rd(STS, v); check("R10 write0", v, 8'hF1);
    wr(STS, 8'h01); rd(STS, v); check("R10 write1", v, 8'hF0);
    wr(GCR, 8'h38); wr(STS, 8'h0F);
    line_pulse(3);
    rd(STS, v); check("R10 active high", v, 8'hF8);
    wr(GCR, 8'h20); wr(STS, 8'h0F);
    line_pulse(0);
    rd(STS, v); check("R10 pair off", v, 8'hF0);

    // R12 interrupt
    wr(GCR, 8'h30); wr(PCR, 8'h82); wr(STS, 8'h0F);
    line_pulse(0);
    check("R12 irq h1", {7'b0, irq}, 8'h01);
    wr(STS, 8'h01); tick(1);
    check("R12 irq cleared", {7'b0, irq}, 8'h00);
    wr(PCR, 8'h80);
    line_pulse(1);
    check("R12 no enable", {7'b0, irq}, 8'h00);
    wr(PCR, 8'h84); tick(1);
    check("R12 irq h2", {7'b0, irq}, 8'h01);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule